// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running calendar (seconds, minutes, hours with a PM bit, weekday, day, month and two-digit year, all BCD) and compares it against a set of alarm registers. Software programs those registers over a simple register bus. Every field has its own compare enable, so software can build an alarm from any subset of fields. For example, it can match on the seconds alone to get a once-a-minute event, or match on hour and minute together to get a daily event.

The compare is done once per seconds update. When every enabled field equals the calendar, the block sets a sticky alarm flag in a status register. A match that persists does not set the flag again. Software clears the flag by writing zero to its bit. An interrupt output is asserted while the flag is set and the alarm interrupt enable in the control register is on. After any alarm register is written, matches are suppressed until a number of 1/64-second periodic ticks have passed. Software waits for those ticks before it enables the alarm interrupt. The status register also holds a sticky periodic-tick flag.

The bus is word addressed on even byte addresses, and address bit 0 is ignored. Writes take effect at the next clock edge. Read data is combinational from the address.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset, all alarm registers, the year enable, the control register and both status flags read as zero, and `alarm_irq_o` and `alarm_flag_o` are low.
- R2: Alarm bytes can be written and read back in full at these addresses: seconds 0x10, minutes 0x12, hours 0x14, weekday 0x16, day 0x18, month 0x1A and year 0x1C. For each of these, `wdata_i[7:0]` is stored and returned on `rdata_o[7:0]`. At 0x1E only bit 7, the year compare enable, is stored. Unmapped addresses read as 0.
- R3: When `sec_tick_i` is high and every enabled field matches the calendar, the alarm flag (status 0x20 bit 0) is set at that clock edge. Each field's enable is bit 7 of its alarm byte, except the year, which uses 0x1E bit 7. The compared bits are: seconds [6:0], minutes [6:0], hours [6:0] with PM in bit 6, weekday [2:0], day [5:0], month [4:0] and year [7:0].
- R4: A field whose enable is 0 takes no part in the compare, whatever its stored value.
- R5: With no field enabled, the alarm flag is never set.
- R6: The flag is set only on a rising match. A match that is still true at the next seconds update does not set the flag again after it has been cleared. The match must first be seen false at a seconds update.
- R7: A write to any of 0x10 to 0x1E suppresses matches from that cycle until `GUARD_TICKS` (default 2) cycles with `per_tick_i` high have passed.
- R8: Writing status 0x20 with a 0 in bit 0 clears the alarm flag, and a 0 in bit 2 clears the periodic flag. A 1 in either bit leaves that flag unchanged.
- R9: `per_tick_i` sets the periodic flag (status bit 2) at that clock edge.
- R10: Control 0x22 stores bits [2:0]: alarm interrupt enable at bit 0, carry interrupt enable at bit 1 and periodic interrupt enable at bit 2. `alarm_irq_o` is high exactly when the alarm flag and bit 0 are both 1.
- R11: When a flag set and a software clear of the alarm flag fall in the same cycle, the set wins.
- R12: Without `sec_tick_i`, a matching calendar never sets the alarm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (6) | Byte address, bit 0 ignored |
| wdata_i | input | DATA_W (16) | Write data |
| rdata_o | output | DATA_W (16) | Read data for `addr_i` |
| cal_sec_i | input | 7 | Calendar seconds, BCD |
| cal_min_i | input | 7 | Calendar minutes, BCD |
| cal_hour_i | input | 7 | Calendar hours, BCD in [5:0], PM in bit 6 |
| cal_wday_i | input | 3 | Calendar weekday |
| cal_day_i | input | 6 | Calendar day of month, BCD |
| cal_mon_i | input | 5 | Calendar month, BCD |
| cal_year_i | input | 8 | Calendar year, BCD |
| sec_tick_i | input | 1 | One-cycle seconds update strobe |
| per_tick_i | input | 1 | One-cycle 1/64-second periodic tick |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The flags, `alarm_irq_o` and every stored register change at the rising edge that samples the write, `sec_tick_i` or `per_tick_i`. `rdata_o` follows `addr_i` within the same cycle. The bench drives inputs on the falling edge. It steps a behavioural model at each rising edge and compares the flag, the interrupt and the read data 5 ns after that edge, so each result is checked in the cycle it becomes due. Guard windows, held matches and colliding set and clear are exercised by exact tick placement.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned YEAR_IDX   = 6;
  localparam int unsigned FLD_W      = 8;
  localparam int unsigned WIDX_W     = 5;

  // word indices (byte address >> 1)
  localparam logic [WIDX_W-1:0] WIDX_ALM  = 5'h08;
  localparam logic [WIDX_W-1:0] WIDX_YEN  = WIDX_ALM + WIDX_W'(NUM_FIELDS);
  localparam logic [WIDX_W-1:0] WIDX_STAT = 5'h10;
  localparam logic [WIDX_W-1:0] WIDX_CTRL = 5'h11;

  localparam int unsigned ST_ALM = 0;
  localparam int unsigned ST_PER = 2;
  localparam int unsigned CTRL_W = 3;
  localparam int unsigned EN_BIT = 7;

  typedef logic [FLD_W-1:0] fld_t;

  function automatic fld_t fld_mask(int unsigned idx);
    case (idx)
      0, 1, 2: return 8'h7f;
      3:       return 8'h07;
      4:       return 8'h3f;
      5:       return 8'h1f;
      default: return 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NF = NUM_FIELDS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [WIDX_W-1:0]          widx_i,
  input  fld_t                       wdata_i,
  output fld_t [NF-1:0]              alm_q_o,
  output logic                       yen_q_o,
  output logic [CTRL_W-1:0]          ctrl_q_o,
  output logic                       alm_wr_o
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          alm_q_o[i] <= '0;
      else if (wr_en_i && widx_i == WIDX_ALM + WIDX_W'(i))  alm_q_o[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      yen_q_o  <= 1'b0;
      ctrl_q_o <= '0;
    end else if (wr_en_i) begin
      if (widx_i == WIDX_YEN)  yen_q_o  <= wdata_i[EN_BIT];
      if (widx_i == WIDX_CTRL) ctrl_q_o <= wdata_i[CTRL_W-1:0];
    end
  end

  assign alm_wr_o = wr_en_i && (widx_i >= WIDX_ALM) && (widx_i <= WIDX_YEN);
endmodule

// File: rtl/cal_field_match.sv
module cal_field_match
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NF = NUM_FIELDS
) (
  input  fld_t [NF-1:0] alm_i,
  input  logic          yen_i,
  input  fld_t [NF-1:0] cal_i,
  output logic          match_o
);
  logic [NF-1:0] en, ok;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    if (i == YEAR_IDX) begin : g_year
      assign en[i] = yen_i;
    end else begin : g_byte
      assign en[i] = alm_i[i][EN_BIT];
    end
    assign ok[i] = !en[i] || (((alm_i[i] ^ cal_i[i]) & fld_mask(i)) == '0);
  end

  // an all-disabled set never matches
  assign match_o = (&ok) && (|en);
endmodule

// File: rtl/cal_alarm_flags.sv
module cal_alarm_flags
  import cal_alarm_pkg::*;
#(
  parameter int unsigned GUARD_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_tick_i,
  input  logic per_tick_i,
  input  logic match_i,
  input  logic alm_wr_i,
  input  logic stat_wr_i,
  input  fld_t stat_wdata_i,
  output logic alm_flag_o,
  output logic per_flag_o
);
  localparam int unsigned GW = $clog2(GUARD_TICKS + 1);

  logic [GW-1:0] guard_q;
  logic          prev_q, hit, set_alm;

  assign hit     = match_i && (guard_q == '0) && !alm_wr_i;
  assign set_alm = sec_tick_i && hit && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      if (alm_wr_i)                        guard_q <= GW'(GUARD_TICKS);
      else if (per_tick_i && guard_q != 0) guard_q <= guard_q - 1'b1;
      if (sec_tick_i)                      prev_q  <= hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_flag_o <= 1'b0;
      per_flag_o <= 1'b0;
    end else begin
      if (set_alm)                                 alm_flag_o <= 1'b1;
      else if (stat_wr_i && !stat_wdata_i[ST_ALM]) alm_flag_o <= 1'b0;
      if (per_tick_i)                              per_flag_o <= 1'b1;
      else if (stat_wr_i && !stat_wdata_i[ST_PER]) per_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned GUARD_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [6:0]        cal_sec_i,
  input  logic [6:0]        cal_min_i,
  input  logic [6:0]        cal_hour_i,
  input  logic [2:0]        cal_wday_i,
  input  logic [5:0]        cal_day_i,
  input  logic [4:0]        cal_mon_i,
  input  logic [7:0]        cal_year_i,
  input  logic              sec_tick_i,
  input  logic              per_tick_i,
  output logic              alarm_flag_o,
  output logic              alarm_irq_o
);
  localparam int unsigned NF = NUM_FIELDS;

  logic [WIDX_W-1:0] widx;
  fld_t              wbyte;
  fld_t [NF-1:0]     alm_q, cal_vec;
  logic              yen_q, alm_wr, match, per_flag, stat_wr;
  logic [CTRL_W-1:0] ctrl_q;
  logic              unused_bits;

  assign widx        = addr_i[WIDX_W:1];
  assign wbyte       = wdata_i[FLD_W-1:0];
  assign unused_bits = ^{addr_i[0], wdata_i[DATA_W-1:FLD_W]};
  assign stat_wr     = wr_en_i && widx == WIDX_STAT;

  assign cal_vec[0] = {1'b0, cal_sec_i};
  assign cal_vec[1] = {1'b0, cal_min_i};
  assign cal_vec[2] = {1'b0, cal_hour_i};
  assign cal_vec[3] = {5'b0, cal_wday_i};
  assign cal_vec[4] = {2'b0, cal_day_i};
  assign cal_vec[5] = {3'b0, cal_mon_i};
  assign cal_vec[6] = cal_year_i;

  cal_alarm_regs #(.NF(NF)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .widx_i(widx), .wdata_i(wbyte),
    .alm_q_o(alm_q), .yen_q_o(yen_q), .ctrl_q_o(ctrl_q), .alm_wr_o(alm_wr)
  );

  cal_field_match #(.NF(NF)) i_match (
    .alm_i(alm_q), .yen_i(yen_q), .cal_i(cal_vec), .match_o(match)
  );

  cal_alarm_flags #(.GUARD_TICKS(GUARD_TICKS)) i_flags (
    .clk_i, .rst_ni, .sec_tick_i, .per_tick_i, .match_i(match),
    .alm_wr_i(alm_wr), .stat_wr_i(stat_wr), .stat_wdata_i(wbyte),
    .alm_flag_o(alarm_flag_o), .per_flag_o(per_flag)
  );

  assign alarm_irq_o = alarm_flag_o && ctrl_q[0];

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NF; i++)
      if (widx == WIDX_ALM + WIDX_W'(i)) rdata_o[FLD_W-1:0] = alm_q[i];
    if (widx == WIDX_YEN)  rdata_o[EN_BIT] = yen_q;
    if (widx == WIDX_STAT) begin
      rdata_o[ST_ALM] = alarm_flag_o;
      rdata_o[ST_PER] = per_flag;
    end
    if (widx == WIDX_CTRL) rdata_o[CTRL_W-1:0] = ctrl_q;
  end
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              sec_tick_i,
  input logic              alarm_flag_o,
  input logic              alarm_irq_o
);
  logic stat_clr, alm_wr;
  assign stat_clr = wr_en_i && addr_i[5:1] == 5'h10 && !wdata_i[0];
  assign alm_wr   = wr_en_i && addr_i[5:1] >= 5'h08 && addr_i[5:1] <= 5'h0f;

  p_set_on_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag_o) |-> $past(sec_tick_i));

  p_clear_by_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_flag_o) |-> $past(stat_clr));

  p_guard_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_wr |=> !$rose(alarm_flag_o));

  p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> alarm_flag_o);
endmodule

bind cal_alarm_cmp cal_alarm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .sec_tick_i(sec_tick_i),
  .alarm_flag_o(alarm_flag_o), .alarm_irq_o(alarm_irq_o)
);

// File: tb/test_cal_alarm_cmp.sv
`timescale 1ns/1ps
module test_cal_alarm_cmp;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, sec_tick_i = 1'b0, per_tick_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [6:0]  cal_sec_i = 7'h30, cal_min_i = 7'h15, cal_hour_i = 7'h49;
  logic [2:0]  cal_wday_i = 3'd3;
  logic [5:0]  cal_day_i = 6'h21;
  logic [4:0]  cal_mon_i = 5'h12;
  logic [7:0]  cal_year_i = 8'h24;
  logic        alarm_flag_o, alarm_irq_o;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #10 clk_i = ~clk_i;

  cal_alarm_cmp i_cal_alarm_cmp (.*);

  // behavioural reference
  int m_alm[7];
  int m_yen, m_ctl, m_flag, m_pflag, m_guard, m_prev;

  function automatic int fmask(int i);
    int m[7] = '{'h7f, 'h7f, 'h7f, 'h07, 'h3f, 'h1f, 'hff};
    return m[i];
  endfunction

  function automatic int calv(int i);
    case (i)
      0: return cal_sec_i;  1: return cal_min_i; 2: return cal_hour_i;
      3: return cal_wday_i; 4: return cal_day_i; 5: return cal_mon_i;
      default: return cal_year_i;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_alm[i]) m_alm[i] = 0;
      m_yen = 0; m_ctl = 0; m_flag = 0; m_pflag = 0; m_guard = 0; m_prev = 0;
    end else begin
      int w;
      bit awr, anyen, allok, hit, en;
      w   = addr_i >> 1;
      awr = wr_en_i && w >= 8 && w <= 15;
      anyen = 0; allok = 1;
      for (int i = 0; i < 7; i++) begin
        en = (i == 6) ? m_yen[0] : m_alm[i][7];
        if (en) begin
          anyen = 1;
          if ((m_alm[i] & fmask(i)) != (calv(i) & fmask(i))) allok = 0;
        end
      end
      hit = anyen && allok && m_guard == 0 && !awr;
      if (sec_tick_i && hit && !m_prev) m_flag = 1;
      else if (wr_en_i && w == 16 && !wdata_i[0]) m_flag = 0;
      if (sec_tick_i) m_prev = hit;
      if (per_tick_i) m_pflag = 1;
      else if (wr_en_i && w == 16 && !wdata_i[2]) m_pflag = 0;
      if (awr) m_guard = 2;
      else if (per_tick_i && m_guard > 0) m_guard--;
      if (wr_en_i) begin
        if (w >= 8 && w <= 14) m_alm[w-8] = wdata_i & 'hff;
        if (w == 15) m_yen = wdata_i[7];
        if (w == 17) m_ctl = wdata_i & 7;
      end
    end
  end

  function automatic int exp_rd();
    int w = addr_i >> 1;
    if (w >= 8 && w <= 14) return m_alm[w-8];
    if (w == 15) return m_yen << 7;
    if (w == 16) return (m_pflag << 2) | m_flag;
    if (w == 17) return m_ctl;
    return 0;
  endfunction

  always @(posedge clk_i) begin
    #5;
    checks++;
    if (alarm_flag_o !== m_flag[0]) begin
      errors++;
      $display("FAIL %s: alarm_flag_o=%0b expected %0b at %0t", cur_req, alarm_flag_o, m_flag[0], $time);
    end
    checks++;
    if (alarm_irq_o !== (m_flag[0] & m_ctl[0])) begin
      errors++;
      $display("FAIL %s: alarm_irq_o=%0b expected %0b at %0t", cur_req, alarm_irq_o, m_flag[0] & m_ctl[0], $time);
    end
    checks++;
    if (rdata_o !== 16'(exp_rd())) begin
      errors++;
      $display("FAIL %s: rdata_o=%h expected %h addr %h at %0t", cur_req, rdata_o, 16'(exp_rd()), addr_i, $time);
    end
  end

  task automatic wr(int a, int d);
    wr_en_i = 1; addr_i = 6'(a); wdata_i = 16'(d);
    @(negedge clk_i); wr_en_i = 0;
  endtask
  task automatic rd(int a);
    addr_i = 6'(a); @(negedge clk_i);
  endtask
  task automatic stick();
    sec_tick_i = 1; @(negedge clk_i); sec_tick_i = 0;
  endtask
  task automatic ptick();
    per_tick_i = 1; @(negedge clk_i); per_tick_i = 0; @(negedge clk_i);
  endtask
  task automatic rearm();
    ptick(); ptick();
  endtask
  task automatic retick(); // drop match then bring it back
    cal_sec_i = 7'h31; stick(); cal_sec_i = 7'h30; stick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R1"; rd('h20); rd('h22); rd('h10);
    rst_ni = 1; rd('h20); rd('h1e);

    cur_req = "R2";
    for (int i = 0; i < 7; i++) wr('h10 + 2*i, 'h5a00 | ('h81 + 17*i));
    wr('h1e, 'hff);
    for (int a = 'h10; a <= 'h26; a++) rd(a);

    cur_req = "R10";
    wr('h22, 'hff); rd('h22); wr('h22, 'h01); rd('h22);

    cur_req = "R7";
    for (int i = 0; i < 7; i++) wr('h10 + 2*i, 0);
    wr('h1e, 0);
    wr('h10, 'hb0); rd('h20);
    stick(); ptick(); stick(); ptick();
    cur_req = "R3"; stick(); rd('h20);
    cur_req = "R10"; wr('h22, 0); rd('h20); wr('h22, 1);

    cur_req = "R6";
    wr('h20, 'h04); stick(); stick(); rd('h20);
    cal_sec_i = 7'h31; stick(); cal_sec_i = 7'h30; stick(); rd('h20);

    cur_req = "R9"; ptick(); rd('h20);
    cur_req = "R8";
    wr('h20, 'h05); rd('h20); wr('h20, 'h01); rd('h20); ptick();
    wr('h20, 'h04); rd('h20);

    cur_req = "R11";
    cal_sec_i = 7'h31; stick(); cal_sec_i = 7'h30;
    wr_en_i = 1; addr_i = 6'h20; wdata_i = 0; sec_tick_i = 1;
    @(negedge clk_i); wr_en_i = 0; sec_tick_i = 0; rd('h20);
    wr('h20, 0);

    cur_req = "R4";
    wr('h12, 'h00); wr('h14, 'hc9); wr('h16, 'h83); wr('h18, 'ha1); wr('h1a, 'h92);
    rearm(); retick(); wr('h20, 0);
    cur_req = "R3"; cal_hour_i = 7'h09; rearm(); retick(); cal_hour_i = 7'h49; retick();
    wr('h20, 0);
    cur_req = "R4"; wr('h1c, 'h25); wr('h1e, 'h80); rearm(); retick();
    wr('h1c, 'h24); rearm(); retick(); wr('h20, 0);

    cur_req = "R5";
    for (int i = 0; i < 6; i++) wr('h10 + 2*i, 0);
    wr('h10, 'h30); wr('h1e, 0); rearm(); retick(); retick(); rd('h20);

    cur_req = "R12";
    wr('h10, 'hb0); rearm();
    cal_sec_i = 7'h31; stick(); cal_sec_i = 7'h30;
    repeat (5) rd('h20);
    cur_req = "R3"; stick(); rd('h20);

    repeat (2) @(negedge clk_i);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule